// File: doc/BRIEF.md
# Per-Packet Symbol Error Counter

This block sits on the receive side of a 100 Mb/s Ethernet physical layer and keeps a statistic of damaged packets. It sees one decoded symbol per strobe, together with a flag that marks the symbol as an invalid code. It also sees a carrier indication that is high inside a packet, and a select that puts the interface in 10 Mb/s mode. It holds a 16-bit count that a management interface reads through a small registered read port.

The count goes up by one for each window that contains at least one invalid symbol. A window is the span of one packet, or one stretch of idle between packets. Every change of the carrier indication starts a new window. The count wraps instead of saturating, and reading it leaves it untouched. While the interface runs at 10 Mb/s nothing is counted.

Top module: `pkt_symerr_counter`

## Requirements
- R1: After reset the count is 0, `rd_valid` is 0 and `rd_data` is 0.
- R2: In 100 Mb/s mode, a strobed symbol (`sym_valid`=1) with `sym_invalid`=1 in a window not yet counted adds exactly one to the count.
- R3: Any further invalid symbols in the same packet window leave the count unchanged.
- R4: Invalid symbols seen while `in_pkt`=0 count once per idle stretch. Every change of `in_pkt` between two cycles opens a fresh window.
- R5: One increment from 16'hFFFF gives 16'h0000.
- R6: A read pulse (`rd_en`=1) makes `rd_valid`=1 in the next cycle, with the count in `rd_data`. Reading never changes the count, so back-to-back reads return the same value.
- R7: A read in the same cycle as an increment returns the value from before that increment.
- R8: `mode_10m` is registered. From the cycle after it is seen high, invalid symbols are not counted. An invalid symbol in the first cycle it is high still counts.
- R9: A window that is open when 10 Mb/s mode takes effect stays uncounted until `in_pkt` changes, even if 100 Mb/s mode returns within that window.
- R10: `sym_invalid` with `sym_valid`=0 has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for symbols and reads |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_valid | input | 1 | A decoded symbol is present this cycle |
| sym_invalid | input | 1 | The present symbol is an invalid code |
| in_pkt | input | 1 | Carrier indication, high inside a packet |
| mode_10m | input | 1 | 1 selects 10 Mb/s operation |
| rd_en | input | 1 | Read request for the count |
| rd_data | output | 16 | Count captured by the last read |
| rd_valid | output | 1 | rd_data was loaded by a read in the previous cycle |

## Verification
Two functions can fall in the same cycle: a management read and a counting increment. The bench raises `rd_en` in the cycle that carries the first invalid symbol of a new packet. The scoreboard expects the value from before the increment, and a following read must show the incremented value. A second pair of functions also coincides: the first cycle of `mode_10m` together with an invalid symbol. The bench provokes this case and expects the error to be counted.

// File: rtl/pkt_symerr_counter.sv
module pkt_symerr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_valid,
  input  logic             sym_invalid,
  input  logic             in_pkt,
  input  logic             mode_10m,
  input  logic             rd_en,
  output logic [CNT_W-1:0] rd_data,
  output logic             rd_valid
);

  logic [CNT_W-1:0] count;
  logic pkt_q, mode_q, done;
  logic err, new_win, done_cur, bump;

  assign err      = sym_valid & sym_invalid;
  assign new_win  = in_pkt ^ pkt_q;
  assign done_cur = done & ~new_win;
  assign bump     = err & ~mode_q & ~done_cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      pkt_q    <= 1'b0;
      mode_q   <= 1'b0;
      done     <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      pkt_q    <= in_pkt;
      mode_q   <= mode_10m;
      done     <= done_cur | err | mode_q;
      rd_valid <= rd_en;
      if (bump)  count   <= count + 1'b1;
      if (rd_en) rd_data <= count;
    end
  end

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> (count == CNT_W'($past(count) + 1'b1)));

  assert_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_cur |=> $stable(count));

  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(count) == '1 && count != $past(count)) |-> (count == '0));

  assert_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (rd_valid && rd_data == $past(count)));

  assert_slow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |=> $stable(count));

endmodule

// File: tb/pkt_symerr_counter_bench.sv
module pkt_symerr_counter_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sym_valid = 0, sym_invalid = 0, in_pkt = 0, mode_10m = 0, rd_en = 0;
  logic [15:0] rd_data;
  logic rd_valid;
  int checks = 0, fails = 0;
  int exp_q[$];
  string tag_q[$];
  bit done_flag = 0;

  always #10 clk = ~clk;

  pkt_symerr_counter u_pkt_symerr_counter (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_invalid(sym_invalid),
    .in_pkt(in_pkt), .mode_10m(mode_10m), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(bit v, bit iv, bit pk, bit m, bit r = 0, int exp = 0, string req = "");
    @(negedge clk);
    sym_valid = v; sym_invalid = iv; in_pkt = pk; mode_10m = m; rd_en = r;
    if (r) begin exp_q.push_back(exp); tag_q.push_back(req); end
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check("R6 unexpected rd_valid", 1, 0);
      else check(tag_q.pop_front(), int'(rd_data), exp_q.pop_front());
    end
  end

  initial begin
    #2000000;
    check("watchdog", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #35;
    check("R1 rd_data", int'(rd_data), 0);
    check("R1 rd_valid", int'(rd_valid), 0);
    @(negedge clk); rst_n = 1'b1;
    cyc(0,0,0,0,1,0,"R1 count");
    cyc(0,1,0,0); cyc(0,1,0,0); cyc(0,1,0,0);
    cyc(0,0,0,0,1,0,"R10");
    cyc(1,0,1,0); cyc(1,1,1,0);
    cyc(1,0,1,0,1,1,"R2");
    cyc(1,1,1,0); cyc(1,1,1,0); cyc(1,1,1,0);
    cyc(1,0,1,0,1,1,"R3");
    cyc(0,0,0,0); cyc(1,1,0,0); cyc(1,1,0,0);
    cyc(0,0,0,0,1,2,"R4 idle once");
    cyc(1,1,1,0); cyc(0,0,0,0); cyc(1,1,0,0);
    cyc(0,0,0,0,1,4,"R4 new windows");
    cyc(0,0,1,0);
    cyc(1,1,1,0,1,4,"R7");
    cyc(0,0,1,0,1,5,"R6 first");
    cyc(0,0,1,0,1,5,"R6 repeat");
    cyc(0,0,0,0);
    cyc(1,1,0,1);
    cyc(1,1,1,1);
    cyc(0,0,0,1,1,6,"R8");
    cyc(0,0,1,1); cyc(0,0,1,0); cyc(1,1,1,0); cyc(0,0,0,0);
    cyc(0,0,0,0,1,6,"R9 blocked");
    cyc(0,0,1,0); cyc(1,1,1,0); cyc(0,0,0,0);
    cyc(0,0,0,0,1,7,"R9 resumed");
    for (int i = 0; i < 65528; i++) cyc(1,1,i[0],0);
    cyc(0,0,0,0,1,65535,"R5 top");
    cyc(1,1,0,0);
    cyc(0,0,0,0,1,0,"R5 wrap");
    cyc(0,0,0,0); cyc(0,0,0,0); cyc(0,0,0,0);
    check("R6 queue drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule